// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block arbitrates between eight interrupt request lines. Each line is latched into a pending register, either on a rising edge or by following the input level, and the choice is made per line. A pending line that is not masked competes for service. The winner is compared with the lines already in service, and the interrupt output is raised only when the winner strictly outranks all of them. Priority is counted from a movable base offset. An end-of-interrupt command or an automatic end-of-interrupt can rotate that base so that the line just served drops to the lowest rank.

The surrounding logic decodes the programming words and turns them into strobes on this block. It also owns the cascading between instances, and it tells this block whether special fully nested operation is active. The block answers acknowledge cycles, poll requests, specific and non-specific end-of-interrupt commands, and direct loads of the priority base. The pending, in-service and mask registers and the base offset are all visible at the ports.

Top module: `irq_prio_resolver`

## Requirements
- R1: For a line whose `level_mode_i` bit is 1, the pending bit takes the value of the request input on every clock edge.
- R2: For a line whose `level_mode_i` bit is 0, the pending bit is set only when the input is high and was low at the previous edge. It then stays set until it is cleared. The remembered level always follows the input.
- R3: Slot k stands for line (k + offset) mod 8, and a smaller slot means higher priority. Candidates are the pending lines whose `mask_o` bit is 0. A mask bit of 1 keeps its line out.
- R4: `irq_o` is 1 only when the best candidate slot is strictly smaller than the best in-service slot. An empty set counts as slot 8. `irq_line_o` gives the winning line.
- R5: When `nest_mode_i` is 1, in-service bit 2 (the cascade line) is left out of the current-priority comparison.
- R6: An acknowledge with `irq_o` at 1 and `auto_eoi_i` at 0 sets the in-service bit of the winner. With `auto_eoi_i` at 1 it sets no in-service bit, and if `rot_auto_i` is also 1 the offset becomes winner + 1. An acknowledge while `irq_o` is 0 has no effect.
- R7: An acknowledge clears the winner's pending bit only if that line is edge-triggered.
- R8: A non-specific EOI clears the highest-priority in-service bit. With `eoi_rotate_i` at 1 it also sets the offset to that line + 1. With nothing in service it does nothing.
- R9: A specific EOI clears the in-service bit of `eoi_line_i`. With `eoi_rotate_i` at 1 it also sets the offset to `eoi_line_i` + 1.
- R10: `poll_line_o` shows the winner while `irq_o` is 1 and shows 7 otherwise. A `poll_i` strobe while `irq_o` is 1 clears both the pending bit and the in-service bit of the winner.
- R11: `rot_set_i` loads the offset with `rot_line_i` + 1 (mod 8). `mask_wr_i` loads the mask from `mask_data_i` in the same cycle as any command.
- R12: Reset clears the pending, in-service, mask and remembered-level registers and the offset.
- R13: If an edge-triggered line is acknowledged in the same cycle that a new rising edge arrives on it, the line ends up pending. The new edge is recorded after the clear.
- R14: When several commands arrive in one cycle, only one takes effect. The order is: taken acknowledge, then taken poll, then specific EOI, then non-specific EOI, then `rot_set_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines |
| level_mode_i | input | 8 | Per-line trigger mode, 1 = level |
| nest_mode_i | input | 1 | Special fully nested operation |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_auto_i | input | 1 | Rotate the base on automatic EOI |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| poll_i | input | 1 | Poll read strobe |
| eoi_spec_i | input | 1 | Specific EOI strobe |
| eoi_ns_i | input | 1 | Non-specific EOI strobe |
| eoi_rotate_i | input | 1 | EOI also rotates the base |
| eoi_line_i | input | 3 | Line named by a specific EOI |
| rot_set_i | input | 1 | Load the base from rot_line_i |
| rot_line_i | input | 3 | Line that becomes lowest priority |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 8 | Mask write data |
| irq_o | output | 1 | Interrupt valid |
| irq_line_o | output | 3 | Winning line |
| poll_line_o | output | 3 | Poll result, 7 when idle |
| pending_o | output | 8 | Pending register |
| in_service_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |
| rot_base_o | output | 3 | Priority base offset |

## Verification
The bench targets cases where a design that wraps slots wrongly after a rotation would serve the wrong line, and where a design that lets a masked or equal-priority request through would raise `irq_o` while a line is still in service. It also checks acknowledges on level-triggered lines, where clearing the pending bit would lose a request that is still active, and an edge arriving during an acknowledge, where doing the clear last would drop the edge. Colliding commands are driven on purpose, so a wrong precedence order shows up as a corrupted in-service register or offset. Setting nested mode with line 2 in service checks that the cascade line can interrupt itself.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ACK,
    CMD_POLL,
    CMD_EOI_SPEC,
    CMD_EOI_NS,
    CMD_ROT_SET
  } irq_cmd_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IW-1:0]      base_i,
  output logic [IW:0]        slot_o,
  output logic [IW-1:0]      line_o
);
  logic [IW-1:0] idx;

  // lowest slot wins; scan downward so the last hit is the smallest
  always_comb begin
    slot_o = (IW+1)'(N_LINES);
    idx    = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      idx = IW'(k) + base_i;
      if (vec_i[idx]) slot_o = (IW+1)'(k);
    end
  end

  assign line_o = slot_o[IW-1:0] + base_i;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] level_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] last_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    // new edge is OR-ed in after the clear
    assign pend_d[i] = level_i[i] ? req_i[i]
                     : ((pend_q[i] & ~clr_i[i]) | (req_i[i] & ~last_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      pend_q <= '0;
    end else begin
      last_q <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int CASCADE_IDX = 2,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] level_mode_i,
  input  logic               nest_mode_i,
  input  logic               auto_eoi_i,
  input  logic               rot_auto_i,
  input  logic               ack_i,
  input  logic               poll_i,
  input  logic               eoi_spec_i,
  input  logic               eoi_ns_i,
  input  logic               eoi_rotate_i,
  input  logic [IW-1:0]      eoi_line_i,
  input  logic               rot_set_i,
  input  logic [IW-1:0]      rot_line_i,
  input  logic               mask_wr_i,
  input  logic [N_LINES-1:0] mask_data_i,
  output logic               irq_o,
  output logic [IW-1:0]      irq_line_o,
  output logic [IW-1:0]      poll_line_o,
  output logic [N_LINES-1:0] pending_o,
  output logic [N_LINES-1:0] in_service_o,
  output logic [N_LINES-1:0] mask_o,
  output logic [IW-1:0]      rot_base_o
);
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASCADE_IDX;

  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] isr_q, isr_d;
  logic [N_LINES-1:0] mask_q;
  logic [IW-1:0]      base_q, base_d;
  logic [N_LINES-1:0] clr;
  logic [N_LINES-1:0] cand, isr_cmp;
  logic [IW:0]        win_slot, cur_slot, hi_slot;
  logic [IW-1:0]      win_line, cur_line, hi_line;
  logic               irq;
  irq_cmd_e           cmd;

  assign cand    = pend & ~mask_q;
  assign isr_cmp = nest_mode_i ? (isr_q & ~CASC_BIT) : isr_q;

  irq_prio_pick #(.N_LINES(N_LINES)) u_pick_req (
    .vec_i(cand), .base_i(base_q), .slot_o(win_slot), .line_o(win_line)
  );
  irq_prio_pick #(.N_LINES(N_LINES)) u_pick_cur (
    .vec_i(isr_cmp), .base_i(base_q), .slot_o(cur_slot), .line_o(cur_line)
  );
  irq_prio_pick #(.N_LINES(N_LINES)) u_pick_eoi (
    .vec_i(isr_q), .base_i(base_q), .slot_o(hi_slot), .line_o(hi_line)
  );

  assign irq = win_slot < cur_slot;

  always_comb begin
    if (ack_i && irq)       cmd = CMD_ACK;
    else if (poll_i && irq) cmd = CMD_POLL;
    else if (eoi_spec_i)    cmd = CMD_EOI_SPEC;
    else if (eoi_ns_i)      cmd = CMD_EOI_NS;
    else if (rot_set_i)     cmd = CMD_ROT_SET;
    else                    cmd = CMD_NONE;
  end

  always_comb begin
    isr_d  = isr_q;
    base_d = base_q;
    clr    = '0;
    unique case (cmd)
      CMD_ACK: begin
        if (!auto_eoi_i)     isr_d[win_line] = 1'b1;
        else if (rot_auto_i) base_d = win_line + IW'(1);
        clr[win_line] = ~level_mode_i[win_line];
      end
      CMD_POLL: begin
        clr[win_line]   = 1'b1;
        isr_d[win_line] = 1'b0;
      end
      CMD_EOI_SPEC: begin
        isr_d[eoi_line_i] = 1'b0;
        if (eoi_rotate_i) base_d = eoi_line_i + IW'(1);
      end
      CMD_EOI_NS: begin
        if (hi_slot != (IW+1)'(N_LINES)) begin
          isr_d[hi_line] = 1'b0;
          if (eoi_rotate_i) base_d = hi_line + IW'(1);
        end
      end
      CMD_ROT_SET: base_d = rot_line_i + IW'(1);
      default: ;
    endcase
  end

  irq_pend_latch #(.N_LINES(N_LINES)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .level_i(level_mode_i), .clr_i(clr), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
      if (mask_wr_i) mask_q <= mask_data_i;
    end
  end

  assign irq_o        = irq;
  assign irq_line_o   = win_line;
  assign poll_line_o  = irq ? win_line : IW'(N_LINES - 1);
  assign pending_o    = pend;
  assign in_service_o = isr_q;
  assign mask_o       = mask_q;
  assign rot_base_o   = base_q;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] req_i,
  input logic [N_LINES-1:0] level_mode_i,
  input logic               auto_eoi_i,
  input logic               ack_i,
  input logic               poll_i,
  input logic               eoi_spec_i,
  input logic [IW-1:0]      eoi_line_i,
  input logic               irq_o,
  input logic [IW-1:0]      irq_line_o,
  input logic [N_LINES-1:0] pending_o,
  input logic [N_LINES-1:0] in_service_o,
  input logic [N_LINES-1:0] mask_o
);
  p_winner_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pending_o[irq_line_o] && !mask_o[irq_line_o]));

  p_no_cand_no_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pending_o & ~mask_o) == '0) |-> !irq_o);

  p_level_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending_o & $past(level_mode_i)) == ($past(req_i) & $past(level_mode_i))));

  p_ack_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !auto_eoi_i) |=> in_service_o[$past(irq_line_o)]);

  p_auto_eoi_keeps_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && auto_eoi_i) |=> $stable(in_service_o));

  p_spec_eoi_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_spec_i && !(irq_o && (ack_i || poll_i))) |=> !in_service_o[$past(eoi_line_i)]);
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .level_mode_i(level_mode_i),
  .auto_eoi_i(auto_eoi_i), .ack_i(ack_i), .poll_i(poll_i),
  .eoi_spec_i(eoi_spec_i), .eoi_line_i(eoi_line_i), .irq_o(irq_o),
  .irq_line_o(irq_line_o), .pending_o(pending_o), .in_service_o(in_service_o),
  .mask_o(mask_o)
);

// File: tb/irq_prio_resolver_tb.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0, level_mode_i = '0, mask_data_i = '0;
  logic       nest_mode_i = 0, auto_eoi_i = 0, rot_auto_i = 0;
  logic       ack_i = 0, poll_i = 0, eoi_spec_i = 0, eoi_ns_i = 0, eoi_rotate_i = 0;
  logic       rot_set_i = 0, mask_wr_i = 0;
  logic [2:0] eoi_line_i = '0, rot_line_i = '0;
  logic       irq_o;
  logic [2:0] irq_line_o, poll_line_o, rot_base_o;
  logic [7:0] pending_o, in_service_o, mask_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_pend, m_isr, m_mask, m_last;
  logic [2:0] m_off;

  always #2.5 clk_i = ~clk_i;

  irq_prio_resolver u_dut (.*);

  function automatic int pick(logic [7:0] v, logic [2:0] off);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] idx;
      idx = 3'(k) + off;
      if (v[idx]) return k;
    end
    return 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_isr = '0; m_mask = '0; m_last = '0; m_off = '0;
  endtask

  task automatic idle();
    ack_i = 0; poll_i = 0; eoi_spec_i = 0; eoi_ns_i = 0; rot_set_i = 0; mask_wr_i = 0;
  endtask

  // inputs are set at a negedge; compare, advance one edge, land on next negedge
  task automatic cycle(input string tag);
    int ps, cs, hs;
    logic e_irq;
    logic [2:0] e_line, hl;
    logic [7:0] n_isr, clr, n_pend;
    logic [2:0] n_off;
    #1;
    ps = pick(m_pend & ~m_mask, m_off);
    cs = pick(nest_mode_i ? (m_isr & 8'hFB) : m_isr, m_off);
    hs = pick(m_isr, m_off);
    e_irq = ps < cs;
    e_line = 3'(ps) + m_off;
    chk(irq_o == e_irq, {tag, " irq"}, {7'd0, irq_o}, {7'd0, e_irq});
    if (e_irq) chk(irq_line_o == e_line, {tag, " line"}, {5'd0, irq_line_o}, {5'd0, e_line});
    chk(poll_line_o == (e_irq ? e_line : 3'd7), {tag, " R10 poll"}, {5'd0, poll_line_o},
        {5'd0, (e_irq ? e_line : 3'd7)});
    chk(pending_o == m_pend, {tag, " pend"}, pending_o, m_pend);
    chk(in_service_o == m_isr, {tag, " isr"}, in_service_o, m_isr);
    chk(mask_o == m_mask, {tag, " mask"}, mask_o, m_mask);
    chk(rot_base_o == m_off, {tag, " base"}, {5'd0, rot_base_o}, {5'd0, m_off});
    n_isr = m_isr; n_off = m_off; clr = '0;
    if (ack_i && e_irq) begin
      if (!auto_eoi_i) n_isr[e_line] = 1;
      else if (rot_auto_i) n_off = e_line + 3'd1;
      if (!level_mode_i[e_line]) clr[e_line] = 1;
    end else if (poll_i && e_irq) begin
      clr[e_line] = 1; n_isr[e_line] = 0;
    end else if (eoi_spec_i) begin
      n_isr[eoi_line_i] = 0;
      if (eoi_rotate_i) n_off = eoi_line_i + 3'd1;
    end else if (eoi_ns_i) begin
      if (hs != 8) begin
        hl = 3'(hs) + m_off;
        n_isr[hl] = 0;
        if (eoi_rotate_i) n_off = hl + 3'd1;
      end
    end else if (rot_set_i) n_off = rot_line_i + 3'd1;
    n_pend = (level_mode_i & req_i) | (~level_mode_i & ((m_pend & ~clr) | (req_i & ~m_last)));
    @(posedge clk_i);
    m_pend = n_pend; m_isr = n_isr; m_off = n_off; m_last = req_i;
    if (mask_wr_i) m_mask = mask_data_i;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    idle(); req_i = '0; level_mode_i = '0; nest_mode_i = 0; auto_eoi_i = 0; rot_auto_i = 0;
    eoi_rotate_i = 0;
    rst_ni = 0; model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R12 reset state
    chk(pending_o == 0 && in_service_o == 0 && mask_o == 0 && rot_base_o == 0 && !irq_o,
        "R12 reset", pending_o | in_service_o | mask_o, 8'h00);
    // R2 edge latch
    req_i = 8'h08; cycle("R2");
    chk(pending_o == 8'h08, "R2 edge set", pending_o, 8'h08);
    cycle("R2 hold");
    ack_i = 1; cycle("R6 R7 ack");
    chk(in_service_o == 8'h08, "R6 isr set", in_service_o, 8'h08);
    req_i = 8'h00; cycle("R2");
    req_i = 8'h20; cycle("R4 lower");
    chk(irq_o == 0, "R4 outranked", {7'd0, irq_o}, 8'h00);
    req_i = 8'h02; cycle("R4 higher");
    cycle("R3");
    eoi_ns_i = 1; cycle("R8 nonspec");
    eoi_ns_i = 1; eoi_rotate_i = 1; cycle("R8 empty");
    eoi_rotate_i = 0;
    rot_set_i = 1; rot_line_i = 3'd1; cycle("R11 rot");
    chk(rot_base_o == 3'd2, "R11 base", {5'd0, rot_base_o}, 8'h02);
    chk(irq_line_o == 3'd5, "R3 rotated winner", {5'd0, irq_line_o}, 8'h05);
    poll_i = 1; cycle("R10 poll");
    cycle("R10");
    mask_wr_i = 1; mask_data_i = 8'h02; cycle("R11 mask");
    chk(poll_line_o == 3'd7, "R10 idle poll", {5'd0, poll_line_o}, 8'h07);
    poll_i = 1; cycle("R10 empty poll");
    // R5 nested
    do_reset();
    req_i = 8'h04; cycle("R5");
    ack_i = 1; cycle("R5 ack");
    req_i = 8'h00; cycle("R5");
    req_i = 8'h04; cycle("R5 reedge");
    cycle("R5 plain");
    nest_mode_i = 1; cycle("R5 nested");
    chk(irq_o == 1 && irq_line_o == 3'd2, "R5 cascade self", {5'd0, irq_line_o}, 8'h02);
    ack_i = 1; cycle("R5 ack nested");
    nest_mode_i = 0;
    // R1 level and R7 on level
    do_reset();
    level_mode_i = 8'h40; req_i = 8'h40; cycle("R1");
    req_i = 8'h00; cycle("R1 drop");
    chk(pending_o == 8'h00, "R1 follows", pending_o, 8'h00);
    req_i = 8'h40; cycle("R1");
    ack_i = 1; cycle("R7 level ack");
    chk(pending_o == 8'h40, "R7 level kept", pending_o, 8'h40);
    eoi_spec_i = 1; eoi_line_i = 3'd6; eoi_rotate_i = 1; cycle("R9 spec");
    chk(in_service_o == 8'h00 && rot_base_o == 3'd7, "R9 spec rotate", in_service_o, 8'h00);
    eoi_rotate_i = 0;
    // R6 auto EOI with rotation
    do_reset();
    auto_eoi_i = 1; rot_auto_i = 1; req_i = 8'h01; cycle("R6");
    ack_i = 1; cycle("R6 auto");
    chk(in_service_o == 8'h00 && rot_base_o == 3'd1, "R6 auto rot", {5'd0, rot_base_o}, 8'h01);
    auto_eoi_i = 0; rot_auto_i = 0;
    // R13 edge during ack
    do_reset();
    req_i = 8'h10; cycle("R13");
    req_i = 8'h00; cycle("R13");
    req_i = 8'h10; ack_i = 1; cycle("R13 ack edge");
    chk(pending_o == 8'h10, "R13 edge kept", pending_o, 8'h10);
    // R14 collision
    ack_i = 1; eoi_spec_i = 1; eoi_line_i = 3'd4; rot_set_i = 1; rot_line_i = 3'd5;
    cycle("R14 collide");
    // random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 40) req_i = 8'($urandom);
      if ($urandom_range(0, 63) == 0) level_mode_i = 8'($urandom);
      if ($urandom_range(0, 31) == 0) nest_mode_i = 1'($urandom);
      if ($urandom_range(0, 31) == 0) begin auto_eoi_i = 1'($urandom); rot_auto_i = 1'($urandom); end
      ack_i      = ($urandom_range(0, 3) == 0);
      poll_i     = ($urandom_range(0, 15) == 0);
      eoi_spec_i = ($urandom_range(0, 7) == 0);
      eoi_ns_i   = ($urandom_range(0, 5) == 0);
      rot_set_i  = ($urandom_range(0, 15) == 0);
      mask_wr_i  = ($urandom_range(0, 15) == 0);
      eoi_rotate_i = 1'($urandom);
      eoi_line_i = 3'($urandom); rot_line_i = 3'($urandom);
      mask_data_i = 8'($urandom) & 8'($urandom);
      cycle("R1 R2 R3 R4 R14 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule